// File: doc/BRIEF.md
# Table-Driven State Machine

This block is a synchronous state machine whose entire behaviour is held in a writable lookup table rather than in fixed gates. Each table word carries two fields: the output bits, and the state the machine moves to next. On every clock edge outside reset, one register captures the word chosen by the current inputs and the current state. As a result, the outputs and the state are both registered and change on the same edge.

The table is filled through a load port while the machine is held in reset, one word per clock. To give the machine a different function, hold it in reset and rewrite the words. No logic changes, and the address path and the register stay as they are.

With the default parameters there are 3 input bits, 4 output bits and 3 state bits. That gives a table of 64 words, each 7 bits wide.

Top module: `table_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is cleared, so `out_bits` and `cur_state` read zero after that edge.
- R2: The table holds 2^(IN_W+ST_W) words of OUT_W+ST_W bits. Bits [ST_W-1:0] of a word are the next state, and bits [OUT_W+ST_W-1:ST_W] are the outputs.
- R3: The table address is {in_bits, cur_state}, with the state in the low ST_W bits and the inputs above them. The address is therefore in_bits*2^ST_W + cur_state.
- R4: At each rising edge with `rst` low, the register captures the addressed word. `out_bits` and `cur_state` show that word's fields from that edge until the next one.
- R5: At a rising edge with `rst` and `load_en` both high, `load_data` is written to the table word at `load_addr`.
- R6: `load_en` has no effect while `rst` is low. The table keeps its contents, and the machine's next outputs follow the old word.
- R7: Reset clears only the register; the table keeps its contents through reset. A word rewritten under reset changes the machine's behaviour on its next use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the register; also enables table loading |
| in_bits | input | IN_W | External machine inputs |
| load_en | input | 1 | Table write strobe, honoured only while rst is high |
| load_addr | input | IN_W+ST_W | Table word address for loading |
| load_data | input | OUT_W+ST_W | Word to store: outputs above, next state in low bits |
| out_bits | output | OUT_W | Registered machine outputs |
| cur_state | output | ST_W | Registered current state |

## Verification
The assertions assume that every table word the machine reads has been written beforehand. Unwritten storage carries no defined value, so the capture and ignore checks compare against whatever it holds. The bench therefore fills all 64 words under reset before it releases the machine, and it keeps `rst` high at time zero so the first edge already sees a defined reset. Random input patterns and random table contents are drawn from a fixed seed. Directed phases add a distinct-word table, loads attempted outside reset, a reset in mid-run and a single-word rewrite.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;
  // Address width of the table: inputs joined with state bits.
  function automatic int unsigned tbl_addr_w(int unsigned in_w, int unsigned st_w);
    return in_w + st_w;
  endfunction

  // Word width: output field above next-state field.
  function automatic int unsigned tbl_word_w(int unsigned out_w, int unsigned st_w);
    return out_w + st_w;
  endfunction

  // Number of words in the table.
  function automatic int unsigned tbl_depth(int unsigned in_w, int unsigned st_w);
    return 1 << (in_w + st_w);
  endfunction
endpackage

// File: rtl/tfsm_addr.sv
module tfsm_addr #(
  parameter int IN_W = 3,
  parameter int ST_W = 3,
  localparam int AW = tfsm_pkg::tbl_addr_w(IN_W, ST_W)
) (
  input  logic [IN_W-1:0] in_bits,
  input  logic [ST_W-1:0] cur_state,
  output logic [AW-1:0]   rd_addr
);
  // R3: state occupies the low-order address bits
  function automatic logic [AW-1:0] join_addr(logic [IN_W-1:0] i, logic [ST_W-1:0] s);
    return {i, s};
  endfunction

  assign rd_addr = join_addr(in_bits, cur_state);
endmodule

// File: rtl/tfsm_table.sv
module tfsm_table #(
  parameter int AW = 6,
  parameter int WW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [WW-1:0] load_data,
  input  logic [AW-1:0] rd_addr,
  output logic [WW-1:0] rd_word
);
  logic [WW-1:0] mem [DEPTH];
  logic          wr_fire;

  // R5/R6: loading is honoured only while the machine is held in reset
  assign wr_fire = rst & load_en;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[load_addr] <= load_data;
  end

  assign rd_word = mem[rd_addr];

  assert_load_lands_R5: assert property (@(posedge clk) disable iff (!rst)
    (load_en) |=> (mem[$past(load_addr)] == $past(load_data)));

  assert_load_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (load_en) |=> (mem[$past(load_addr)] == $past(mem[load_addr])));
endmodule

// File: rtl/tfsm_word_reg.sv
module tfsm_word_reg #(
  parameter int WW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WW-1:0] d_word,
  output logic [WW-1:0] q_word
);
  always_ff @(posedge clk) begin
    if (rst) q_word <= '0;
    else     q_word <= d_word;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (q_word == '0));

  assert_captures_word_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (q_word == $past(d_word)));
endmodule

// File: rtl/table_fsm.sv
module table_fsm #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 4,
  parameter int ST_W  = 3,
  localparam int AW = tfsm_pkg::tbl_addr_w(IN_W, ST_W),
  localparam int WW = tfsm_pkg::tbl_word_w(OUT_W, ST_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_bits,
  input  logic             load_en,
  input  logic [AW-1:0]    load_addr,
  input  logic [WW-1:0]    load_data,
  output logic [OUT_W-1:0] out_bits,
  output logic [ST_W-1:0]  cur_state
);
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_word;
  logic [WW-1:0] q_word;

  tfsm_addr #(.IN_W(IN_W), .ST_W(ST_W)) u_addr (
    .in_bits  (in_bits),
    .cur_state(cur_state),
    .rd_addr  (rd_addr)
  );

  tfsm_table #(.AW(AW), .WW(WW)) u_table (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_addr(load_addr),
    .load_data(load_data),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

  tfsm_word_reg #(.WW(WW)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .d_word(rd_word),
    .q_word(q_word)
  );

  // R2: word split, outputs above the next-state field
  assign cur_state = q_word[ST_W-1:0];
  assign out_bits  = q_word[WW-1:ST_W];

  assert_field_split_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (cur_state == $past(rd_word[ST_W-1:0]) &&
                out_bits  == $past(rd_word[WW-1:ST_W])));

  assert_addr_order_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (rd_addr == AW'($past(in_bits) * (2 ** ST_W)) + AW'(cur_state)) ||
               ($past(in_bits) != in_bits));
endmodule

// File: tb/tb_table_fsm.sv
`timescale 1ns/1ps
module tb_table_fsm;
  localparam int IN_W = 3, OUT_W = 4, ST_W = 3;
  localparam int AW = IN_W + ST_W, WW = OUT_W + ST_W, DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0] in_bits = '0;
  logic load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [WW-1:0] load_data = '0;
  logic [OUT_W-1:0] out_bits;
  logic [ST_W-1:0] cur_state;

  int checks = 0, fails = 0;
  int tab [DEPTH];
  int st = 0;

  always #2.5 clk = ~clk;

  table_fsm #(.IN_W(IN_W), .OUT_W(OUT_W), .ST_W(ST_W)) dut (
    .clk(clk), .rst(rst), .in_bits(in_bits), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data),
    .out_bits(out_bits), .cur_state(cur_state));

  function automatic int addr_of(int i, int s);
    return i * (1 << ST_W) + s;
  endfunction
  function automatic int st_of(int w);
    return w % (1 << ST_W);
  endfunction
  function automatic int out_of(int w);
    return w / (1 << ST_W);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // called at a negedge; writes under reset (R5)
  task automatic put(int a, int w);
    rst = 1'b1; load_en = 1'b1; load_addr = AW'(a); load_data = WW'(w);
    @(posedge clk); #1;
    tab[a] = w; st = 0;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // called at a negedge; one machine cycle with rst low
  task automatic step(int i, string tag);
    int w;
    rst = 1'b0; in_bits = IN_W'(i);
    w = tab[addr_of(i, st)];
    @(posedge clk); #1;
    chk({tag, " out"}, int'(out_bits), out_of(w));
    chk({tag, " state"}, int'(cur_state), st_of(w));
    st = st_of(w);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 reset out", int'(out_bits), 0);
    chk("R1 reset state", int'(cur_state), 0);

    // R2 R3 R4: distinct words so any wrong address or field split shows
    for (int a = 0; a < DEPTH; a++) put(a, (a * 5 + 3) % (1 << WW));
    for (int n = 0; n < 40; n++) step(n % (1 << IN_W), "R3 distinct");
    for (int n = 0; n < 60; n++) step(int'($urandom_range((1 << IN_W) - 1)), "R4 distinct rnd");

    // R5 R2: random table contents
    for (int a = 0; a < DEPTH; a++) put(a, int'($urandom_range((1 << WW) - 1)));
    for (int n = 0; n < 300; n++) step(int'($urandom_range((1 << IN_W) - 1)), "R5 rnd table");

    // R6: load strobes outside reset aimed at the word about to be read
    for (int n = 0; n < 40; n++) begin
      int i;
      i = int'($urandom_range((1 << IN_W) - 1));
      load_en = 1'b1;
      load_addr = AW'(addr_of(i, st));
      load_data = ~WW'(tab[addr_of(i, st)]);
      step(i, "R6 ignored load");
    end
    load_en = 1'b0;

    // R1 R7: reset mid-run, table survives
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 midrun out", int'(out_bits), 0);
    chk("R1 midrun state", int'(cur_state), 0);
    st = 0;
    @(negedge clk);
    for (int n = 0; n < 30; n++) step(int'($urandom_range((1 << IN_W) - 1)), "R7 kept table");

    // R7: rewrite the word read from state 0 with input 5
    put(addr_of(5, 0), (9 << ST_W) + 6);
    step(5, "R7 rewritten");
    chk("R7 rewritten out", int'(out_bits), 9);
    chk("R7 rewritten state", int'(cur_state), 6);
    for (int n = 0; n < 50; n++) step(int'($urandom_range((1 << IN_W) - 1)), "R7 after rewrite");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule